// File: doc/BRIEF.md
# Timer Channel Tick Gate and Prescaler

This block sits in front of a bank of timer counters and decides, cycle by cycle, which channels may count. There are ten channels: eight general timers, one OS-timer channel and one watchdog channel. Each channel chooses one of three tick sources through a one-hot selection: the peripheral clock enable, a slow real-time tick, or an external tick. It then divides that source by a power of four and emits a one-cycle count-enable pulse. All three sources are single-cycle enable pulses in the system clock domain. The output is a pulse and never a derived clock.

A shared stop vector gates every channel. Software never writes this vector directly. A write-one-to-set port stops channels, and a write-one-to-clear port starts them. A status address reads the vector back. A channel's control word (source selection and prescale code) is locked while that channel is stopped, so software must start a channel before it configures it.

The register bus is a plain single-cycle interface: address, write strobe, write data and combinational read data. Address map: 0 reads stop status; 1 is the stop-set port; 2 is the stop-clear port; 16+c is the control word of channel c, where channels 0..7 are general, 8 is the OS timer and 9 is the watchdog. Any other address reads 0.

Top module: `timer_tick_gate`

## Requirements
- R1: After reset, the stop status reads 0x0001_80FF (every channel stopped), every control word reads 0, and no tick is produced.
- R2: In the stop status word and in both stop ports, general channel c uses bit c (0..7), the OS-timer channel uses bit 15 and the watchdog channel uses bit 16. A status bit of 1 means the channel is gated off, and all other status bits read 0.
- R3: A channel whose stop bit is 1 produces no tick in that cycle.
- R4: A write to address 1 sets the stop bit of every channel whose mapped data bit is 1, and leaves the other channels unchanged.
- R5: A write to address 2 clears the stop bit of every channel whose mapped data bit is 1, and leaves the other channels unchanged.
- R6: A write to a channel's control word (address 16+c) while that channel is stopped is ignored, and the stored word stays unchanged.
- R7: Control bits 2:0 select the source one-hot: 001 selects the peripheral tick, 010 the real-time tick and 100 the external tick. Any other pattern produces no ticks.
- R8: Control bits 5:3 hold a prescale code n. A running channel ticks on every 4^n-th pulse of its selected source (1, 4, 16, 64, 256, 1024 for n = 0..5), and codes 6 and 7 divide by 1024.
- R9: A channel's prescale count returns to zero in every cycle in which the channel is stopped, and on every accepted control write. The next tick therefore comes on exactly the 4^n-th selected pulse after the channel restarts or is reconfigured.
- R10: Reading address 16+c returns the 16-bit control word as last accepted, zero-extended to 32 bits.
- R11: A tick lasts one cycle and is asserted combinationally, in the same cycle as the selected source pulse that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_pclk | input | 1 | Peripheral-clock tick pulse |
| src_rtc | input | 1 | Real-time tick pulse |
| src_ext | input | 1 | External tick pulse |
| tick_out | output | 10 | Count-enable pulse per channel (0..7 general, 8 OS timer, 9 watchdog) |

## Verification
The assertions assume that the source inputs are clean single-cycle-capable enables sampled on the system clock. They also assume that only one bus access happens per cycle, so a stop-set and a stop-clear can never reach the same channel together. The stimulus drives every input only at the falling edge. The bus carries one address per cycle, and the random phase picks its addresses from the mapped set plus a few unmapped ones. Writes happen on roughly one cycle in sixteen, so the long dividers can still complete between reconfigurations.

// File: rtl/timer_tick_gate.sv
module timer_tick_gate #(
  parameter int NUM_GEN   = 8,
  parameter int CTRL_W    = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int OS_BIT    = 15,
  parameter int WD_BIT    = 16,
  parameter int PS_MAX    = 5,
  parameter int CTRL_BASE = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      src_pclk,
  input  logic                      src_rtc,
  input  logic                      src_ext,
  output logic [NUM_GEN+1:0]        tick_out
);
  localparam int NCH   = NUM_GEN + 2;
  localparam int CNT_W = 2 * PS_MAX;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);

  function automatic int stop_pos(input int ch);
    if (ch < NUM_GEN) return ch;
    else if (ch == NUM_GEN) return OS_BIT;
    else return WD_BIT;
  endfunction

  logic [NCH-1:0]             stop_q;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]  cnt_q;
  logic [NCH-1:0][CNT_W-1:0]  lim;
  logic [NCH-1:0]             pick, ctrl_hit, set_m, clr_m;

  wire wr_set = bus_wr && bus_addr == A_SET;
  wire wr_clr = bus_wr && bus_addr == A_CLR;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int POS = stop_pos(g);

    assign set_m[g]    = wr_set && bus_wdata[POS];
    assign clr_m[g]    = wr_clr && bus_wdata[POS];
    assign ctrl_hit[g] = bus_wr && bus_addr == ADDR_W'(CTRL_BASE + g) && !stop_q[g];

    always_comb begin
      case (ctrl_q[g][2:0])
        3'b001:  pick[g] = src_pclk;
        3'b010:  pick[g] = src_rtc;
        3'b100:  pick[g] = src_ext;
        default: pick[g] = 1'b0;
      endcase
    end

    logic [2:0]     code;
    logic [CNT_W:0] span;
    assign code   = (int'(ctrl_q[g][5:3]) > PS_MAX) ? 3'(PS_MAX) : ctrl_q[g][5:3];
    assign span   = (CNT_W+1)'(1) << (2 * code);
    assign lim[g] = CNT_W'(span - 1'b1);

    assign tick_out[g] = !stop_q[g] && pick[g] && cnt_q[g] == lim[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stop_q[g] <= 1'b1;
        ctrl_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else begin
        if (set_m[g])      stop_q[g] <= 1'b1;
        else if (clr_m[g]) stop_q[g] <= 1'b0;
        if (ctrl_hit[g])   ctrl_q[g] <= bus_wdata[CTRL_W-1:0];
        if (stop_q[g] || ctrl_hit[g]) cnt_q[g] <= '0;
        else if (pick[g])  cnt_q[g] <= tick_out[g] ? '0 : cnt_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)
      for (int i = 0; i < NCH; i++) bus_rdata[stop_pos(i)] = stop_q[i];
    for (int i = 0; i < NCH; i++)
      if (bus_addr == ADDR_W'(CTRL_BASE + i)) bus_rdata = DATA_W'(ctrl_q[i]);
  end
endmodule

// File: rtl/timer_tick_gate_chk.sv
module timer_tick_gate_chk #(
  parameter int NUM_GEN   = 8,
  parameter int CTRL_W    = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int OS_BIT    = 15,
  parameter int WD_BIT    = 16,
  parameter int CTRL_BASE = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic                             bus_wr,
  input logic [DATA_W-1:0]                bus_wdata,
  input logic                             src_pclk,
  input logic                             src_rtc,
  input logic                             src_ext,
  input logic [NUM_GEN+1:0]               tick_out,
  input logic [NUM_GEN+1:0]               stop_q,
  input logic [NUM_GEN+1:0][CTRL_W-1:0]   ctrl_q
);
  localparam int NCH = NUM_GEN + 2;

  logic [NCH-1:0] wmask;
  always_comb
    for (int i = 0; i < NCH; i++)
      wmask[i] = bus_wdata[(i < NUM_GEN) ? i : (i == NUM_GEN ? OS_BIT : WD_BIT)];

  p_stopped_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out & stop_q) == '0);

  p_tick_needs_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|tick_out) |-> (src_pclk || src_rtc || src_ext));

  p_set_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> ((stop_q & $past(wmask)) == $past(wmask)));

  p_clr_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> ((stop_q & $past(wmask)) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_locked_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CTRL_BASE + g) && stop_q[g]) |=> $stable(ctrl_q[g]));

    p_bad_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ctrl_q[g][2:0]) != 1) |-> !tick_out[g]);
  end
endmodule

bind timer_tick_gate timer_tick_gate_chk #(
  .NUM_GEN(NUM_GEN), .CTRL_W(CTRL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .OS_BIT(OS_BIT), .WD_BIT(WD_BIT), .CTRL_BASE(CTRL_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .src_pclk(src_pclk), .src_rtc(src_rtc),
  .src_ext(src_ext), .tick_out(tick_out), .stop_q(stop_q), .ctrl_q(ctrl_q)
);

// File: tb/test_timer_tick_gate.sv
module test_timer_tick_gate;
  localparam int NCH = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_pclk = 0, src_rtc = 0, src_ext = 0;
  logic [9:0]  tick_out;

  timer_tick_gate i_timer_tick_gate (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pclk(src_pclk),
    .src_rtc(src_rtc), .src_ext(src_ext), .tick_out(tick_out)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic        m_stop [NCH];
  logic [15:0] m_ctrl [NCH];
  int          m_cnt  [NCH];
  int          tcount [NCH];
  bit          done = 0;

  function automatic int spos(int ch);
    return ch < 8 ? ch : (ch == 8 ? 15 : 16);
  endfunction

  function automatic logic m_pulse(int ch, logic p, logic r, logic e);
    case (m_ctrl[ch][2:0])
      3'b001: return p;
      3'b010: return r;
      3'b100: return e;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int m_lim(int ch);
    int n = int'(m_ctrl[ch][5:3]);
    if (n > 5) n = 5;
    return (1 << (2 * n)) - 1;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    logic [31:0] v = '0;
    if (a == 0) for (int i = 0; i < NCH; i++) v[spos(i)] = m_stop[i];
    for (int i = 0; i < NCH; i++) if (a == 5'(16 + i)) v = {16'h0, m_ctrl[i]};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [4:0] a, logic w, logic [31:0] d, logic p, logic r, logic e);
    logic [9:0] exp_t;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    src_pclk = p; src_rtc = r; src_ext = e;
    #1;
    for (int i = 0; i < NCH; i++)
      exp_t[i] = !m_stop[i] && m_pulse(i, p, r, e) && m_cnt[i] == m_lim(i);
    check("R3 R7 R8 R11 tick vector", 32'(tick_out), 32'(exp_t));
    check("R2 R10 read data", bus_rdata, m_read(a));
    for (int i = 0; i < NCH; i++) begin
      logic hit = w && a == 5'(16 + i) && !m_stop[i];
      if (tick_out[i]) tcount[i]++;
      if (m_stop[i] || hit) m_cnt[i] = 0;
      else if (m_pulse(i, p, r, e)) m_cnt[i] = exp_t[i] ? 0 : m_cnt[i] + 1;
      if (hit) m_ctrl[i] = d[15:0];
      if (w && a == 1 && d[spos(i)]) m_stop[i] = 1;
      else if (w && a == 2 && d[spos(i)]) m_stop[i] = 0;
    end
  endtask

  task automatic idle(logic [4:0] a);
    cyc(a, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NCH; i++) tcount[i] = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(10 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NCH; i++) begin
      m_stop[i] = 1; m_ctrl[i] = 0; m_cnt[i] = 0; tcount[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    idle(0);
    check("R1 status after reset", bus_rdata, 32'h0001_80FF);
    idle(16);
    check("R1 control after reset", bus_rdata, 32'h0);
    cyc(0, 0, 0, 1, 1, 1);
    check("R1 no tick after reset", 32'(tick_out), 32'h0);

    // R6 locked while stopped
    cyc(16, 1, 32'h0009, 0, 0, 0);
    idle(16);
    check("R6 write ignored while stopped", bus_rdata, 32'h0);

    // R5 clear, R2 bit map
    cyc(2, 1, 32'h0001_8001, 0, 0, 0);
    idle(0);
    check("R5 R2 stop clear", bus_rdata, 32'h0000_00FE);
    // R4 set with zeros elsewhere
    cyc(1, 1, 32'h0000_8000, 0, 0, 0);
    idle(0);
    check("R4 R2 stop set OS bit", bus_rdata, 32'h0000_80FE);
    cyc(2, 1, 32'h0000_8000, 0, 0, 0);

    // R8 divide by 4 on peripheral tick
    cyc(16, 1, 32'h0000_0009, 0, 0, 0);
    idle(16);
    check("R10 readback", bus_rdata, 32'h0009);
    clear_counts();
    repeat (12) cyc(0, 0, 0, 1, 0, 0);
    check("R8 divide by 4", tcount[0], 3);

    // R7 invalid select
    cyc(16, 1, 32'h0000_0003, 0, 0, 0);
    clear_counts();
    repeat (10) cyc(0, 0, 0, 1, 1, 1);
    check("R7 invalid select silent", tcount[0], 0);

    // R7 real-time source only
    cyc(16, 1, 32'h0000_0002, 0, 0, 0);
    clear_counts();
    repeat (5) cyc(0, 0, 0, 1, 0, 0);
    check("R7 peripheral ignored on rtc select", tcount[0], 0);
    repeat (5) cyc(0, 0, 0, 0, 1, 0);
    check("R7 rtc select", tcount[0], 5);

    // R9 stop clears the count
    cyc(16, 1, 32'h0000_0011, 0, 0, 0);
    repeat (10) cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 1, 32'h1, 0, 0, 0);
    cyc(2, 1, 32'h1, 0, 0, 0);
    clear_counts();
    repeat (15) cyc(0, 0, 0, 1, 0, 0);
    check("R9 no tick before 16 after restart", tcount[0], 0);
    cyc(0, 0, 0, 1, 0, 0);
    check("R9 tick on 16th after restart", tcount[0], 1);

    // R8 code 7 on watchdog, external source
    cyc(25, 1, 32'h0000_003C, 0, 0, 0);
    clear_counts();
    repeat (1023) cyc(0, 0, 0, 0, 0, 1);
    check("R8 code 7 no tick before 1024", tcount[9], 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R8 code 7 divide by 1024", tcount[9], 1);

    // random phase
    for (int k = 0; k < 40000; k++) begin
      logic [4:0]  a;
      logic        w;
      logic [31:0] d;
      int sel = $urandom % 16;
      a = (sel < 10) ? 5'(16 + sel) : (sel < 12 ? 5'd2 : (sel == 12 ? 5'd1 : (sel == 13 ? 5'd0 : 5'(3 + $urandom % 12))));
      w = ($urandom % 16) == 0;
      d = $urandom;
      if (a >= 16) begin
        logic [2:0] s;
        int c = $urandom % 5;
        s = (c == 0) ? 3'b001 : (c == 1) ? 3'b010 : (c == 2) ? 3'b100 : 3'($urandom);
        d[2:0] = s;
        d[5:3] = 3'($urandom % 4);
      end
      if (a == 1 && ($urandom % 2)) d = 32'h0;
      cyc(a, w, d, 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule